// File: doc/BRIEF.md
# Page-Mode Asynchronous DRAM Controller

This block connects a clocked host to an asynchronous DRAM with a multiplexed address bus: 10 row bits, 10 column bits and a 4-bit data path. A host request carries a 20-bit word address, a write flag and write data. The controller splits the address into a row half and a column half. It drives the row onto the shared address pins and lowers the row strobe. It then drives the column and lowers the column strobe. After the access it leaves the row open, so a later request to the same row costs only a column cycle. The next column address is already on the pins while the column strobe is still high, so the access starts from the address and not from the strobe edge.

Every strobe interval is a parameter counted in clock cycles. The read sample point follows from the later of the column-strobe access and the column-address access, and the row-to-column delay is stretched until the row access time is also met. Writes are early writes: the write strobe falls before the column strobe and the output enable stays high. An open page is closed in three cases: a request to another row arrives, the row-strobe low time nears its limit, or an external refresh agent asks for the bus. The bus is granted only once the page is closed.

Host requests use a valid/ready handshake. The request fields must be held stable while `req_valid` is high and `req_ready` is low. The transfer happens on the clock edge where both are high. `req_ready` is low during every access and precharge, and also whenever a refresh is requested or granted. Read data comes back as a one-cycle `rd_valid` pulse with no back-pressure, in request order.

Top module: `pagemode_dram_ctrl`

## Requirements
- R1: After reset all four strobes (row, column, write, output enable) are high (inactive), the data drivers are off, `rd_valid` and `refresh_gnt` are low, and `req_ready` is high while `refresh_req` is low.
- R2: Address bits [19:10] are the row and bits [9:0] are the column. The row is on `dram_addr` in the cycle before the row strobe falls and in the cycle where it falls. The column is on `dram_addr` in the cycle before the column strobe falls and in the cycle where it falls.
- R3: A request to the row that is already open is served by a column cycle alone; the row strobe stays low.
- R4: A request to a different row raises the row strobe, which stays high for at least T_RP cycles before the new row is opened.
- R5: A write lowers the write strobe at least one cycle before the column strobe falls and holds it low while the column strobe is low. The write data is driven during that time and the output enable stays high.
- R6: Read data is sampled after the column strobe has been low for T_CAC cycles, the column address has been stable for T_AA cycles and the row strobe has been low for T_RAC cycles. The data is returned as a single-cycle `rd_valid` pulse, in request order.
- R7: The output enable is low only while the column strobe is low during a read.
- R8: The row strobe is never low for more than T_RAS_MAX consecutive cycles. The page is closed when this limit nears, even if same-row requests are waiting.
- R9: `refresh_gnt` is high only while the row and column strobes are both high. An open page is closed when `refresh_req` is raised.
- R10: The column strobe falls only while the row strobe is low. The column strobe falls no sooner than T_RCD cycles after the row strobe falls. Between two column cycles in one page, the column strobe stays high for at least T_CP cycles.
- R11: No request is accepted while `refresh_req` or `refresh_gnt` is high. A request held under back-pressure is accepted later, and none is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in [19:10], column in [9:0] |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 4 | Read data |
| refresh_req | input | 1 | Refresh agent asks for the bus |
| refresh_gnt | output | 1 | Bus yielded, page closed |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 4 | Data returned by the DRAM |

## Verification
The bench's DRAM model returns the inverted word until the column-strobe, column-address and row-strobe access windows have all elapsed. A controller that samples even one cycle early therefore returns corrupted read data. Bursts of same-row requests longer than one row-strobe budget check two failure modes: a controller that never closes the page breaks the low-time limit, and one that closes it on every access shows extra row openings. A refresh request raised while a page is open, with a host request already waiting, checks that the bus is granted only with the strobes high and that the waiting request is neither accepted during the grant nor lost afterwards. Interleaved rows and reads in reverse order check the address split and the precharge gap before each reopened row.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REF, ST_RSET, ST_RCD, ST_CSET, ST_CASL, ST_CP, ST_PAGE, ST_PRE
  } pg_state_e;

  function automatic int cyc_max(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pgdram_cnt.sv
module pgdram_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (clr)              q <= '0;
    else if (inc && (q != '1)) q <= q + 1'b1;
  end
endmodule

// File: rtl/pgdram_rdcap.sv
module pgdram_rdcap #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] d,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap;
      if (cap) rd_data <= d;
    end
  end

  // R6: each returned word is a single-cycle pulse
  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/pagemode_dram_ctrl.sv
module pagemode_dram_ctrl
  import pgdram_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 10,
  parameter int DQ_W      = 4,
  parameter int T_RCD     = 4,
  parameter int T_RAC     = 16,
  parameter int T_AA      = 8,
  parameter int T_CAC     = 4,
  parameter int T_CP      = 2,
  parameter int T_RP      = 12,
  parameter int T_RAS_MAX = 2000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rd_valid,
  output logic [DQ_W-1:0]        rd_data,
  input  logic                   refresh_req,
  output logic                   refresh_gnt,
  output logic [COL_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DQ_W-1:0]        dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DQ_W-1:0]        dram_dq_in
);
  localparam int CAS_LO    = cyc_max(T_CAC, T_AA - 1);
  localparam int RCD_EFF   = cyc_max(T_RCD, T_RAC - 1 - CAS_LO);
  localparam int ACC_CYC   = CAS_LO + T_CP + 2;
  localparam int RAS_LIMIT = T_RAS_MAX - ACC_CYC;
  localparam int TMAX      = cyc_max(cyc_max(RCD_EFF, CAS_LO), cyc_max(T_CP, T_RP));
  localparam int TW        = $clog2(TMAX + 1);
  localparam int AW        = $clog2(T_RAS_MAX + 1);

  pg_state_e st, st_nxt;
  logic [TW-1:0]    tcnt;
  logic [AW-1:0]    rage;
  logic             cur_we, pend;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  logic [DQ_W-1:0]  cur_wdata;
  logic             acc, same_row, expired, rd_cap, wr_phase;

  pgdram_cnt #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(st_nxt != st), .inc(1'b1), .q(tcnt));

  pgdram_cnt #(.W(AW)) u_rage (
    .clk(clk), .rst_n(rst_n), .clr(dram_ras_n), .inc(1'b1), .q(rage));

  assign same_row  = (req_addr[ROW_W+COL_W-1:COL_W] == cur_row);
  assign expired   = (rage >= AW'(RAS_LIMIT));
  assign req_ready = !refresh_req && ((st == ST_IDLE) || (st == ST_PAGE && !expired));
  assign acc       = req_valid && req_ready;

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE: if (refresh_req) st_nxt = ST_REF;
               else if (req_valid) st_nxt = ST_RSET;
      ST_REF:  if (!refresh_req) st_nxt = ST_IDLE;
      ST_RSET: st_nxt = ST_RCD;
      ST_RCD:  if (tcnt == TW'(RCD_EFF - 1)) st_nxt = ST_CSET;
      ST_CSET: st_nxt = ST_CASL;
      ST_CASL: if (tcnt == TW'(CAS_LO - 1)) st_nxt = ST_CP;
      ST_CP:   if (tcnt == TW'(T_CP - 1)) st_nxt = ST_PAGE;
      ST_PAGE: if (refresh_req || expired) st_nxt = ST_PRE;
               else if (req_valid) st_nxt = same_row ? ST_CSET : ST_PRE;
      ST_PRE:  if (tcnt == TW'(T_RP - 1)) st_nxt = pend ? ST_RSET : ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_we    <= 1'b0;
      cur_row   <= '0;
      cur_col   <= '0;
      cur_wdata <= '0;
      pend      <= 1'b0;
    end else begin
      st <= st_nxt;
      if (acc) begin
        cur_we    <= req_we;
        cur_row   <= req_addr[ROW_W+COL_W-1:COL_W];
        cur_col   <= req_addr[COL_W-1:0];
        cur_wdata <= req_wdata;
      end
      if (st == ST_PAGE && acc && !same_row) pend <= 1'b1;
      else if (st == ST_RSET)                pend <= 1'b0;
    end
  end

  assign wr_phase    = cur_we && (st == ST_CSET || st == ST_CASL);
  assign dram_ras_n  = !(st == ST_RCD || st == ST_CSET || st == ST_CASL ||
                         st == ST_CP || st == ST_PAGE);
  assign dram_cas_n  = (st != ST_CASL);
  assign dram_we_n   = !wr_phase;
  assign dram_oe_n   = !(st == ST_CASL && !cur_we);
  assign dram_dq_oe  = wr_phase;
  assign dram_dq_out = cur_wdata;
  assign refresh_gnt = (st == ST_REF);
  assign rd_cap      = (st == ST_CASL) && (tcnt == TW'(CAS_LO - 1)) && !cur_we;

  always_comb begin
    case (st)
      ST_RSET, ST_RCD: dram_addr = COL_W'(cur_row);
      ST_IDLE, ST_REF: dram_addr = '0;
      default:         dram_addr = cur_col;
    endcase
  end

  pgdram_rdcap #(.DW(DQ_W)) u_rdcap (
    .clk(clk), .rst_n(rst_n), .cap(rd_cap), .d(dram_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data));

  // R2: address held across each strobe fall
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) || $fell(dram_cas_n)) |-> $stable(dram_addr));
  // R5: write strobe already low when the column strobe falls
  p_we_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));
  // R5: write cycle drives data with output enable high
  p_wr_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_we_n && !dram_cas_n) |-> (dram_oe_n && dram_dq_oe));
  // R7: output enable only in a read column cycle
  p_oe_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> (!dram_cas_n && dram_we_n));
  // R8: row strobe low time bounded
  p_ras_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> (int'(rage) < T_RAS_MAX));
  // R9: grant only with the bus idle
  p_gnt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_gnt |-> (dram_ras_n && dram_cas_n && !req_ready));
  // R10: column strobe only inside an open row
  p_cas_in_row_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
endmodule

// File: tb/tb_pagemode_dram_ctrl.sv
module tb_pagemode_dram_ctrl;
  localparam int T_RCD = 4, T_RAC = 16, T_AA = 8, T_CAC = 4, T_CP = 2, T_RP = 12;
  localparam int T_RAS_MAX = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, refresh_req = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0, dram_dq_in = '0;
  logic req_ready, rd_valid, refresh_gnt;
  logic [3:0] rd_data, dram_dq_out;
  logic [9:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;

  always #2.5 clk = ~clk;

  pagemode_dram_ctrl #(.T_RCD(T_RCD), .T_RAC(T_RAC), .T_AA(T_AA), .T_CAC(T_CAC),
                       .T_CP(T_CP), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .refresh_req(refresh_req),
    .refresh_gnt(refresh_gnt), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  int n_chk = 0, n_fail = 0;
  logic [3:0] ref_mem [int];
  logic [3:0] dram_mem [int];
  logic [3:0] exp_q [$];
  int last_acc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural DRAM model and per-cycle protocol checks
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
  logic [9:0] p_addr = '0, row_l = '0, col_l = '0;
  int hi_run = 1000, lo_run = 0, cas_hi = 1000, cas_lo = 0, addr_run = 0;
  int falls = 0;
  bit first_cas = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !dram_ras_n) begin
        falls++;
        chk(dram_addr == p_addr, "R2 row addr stable at row strobe fall", dram_addr, p_addr);
        chk(hi_run >= T_RP, "R4 row precharge length", hi_run, T_RP);
        row_l = dram_addr;
        first_cas = 1'b1;
      end
      if (p_cas && !dram_cas_n) begin
        chk(!dram_ras_n, "R10 column strobe inside row", dram_ras_n, 0);
        chk(dram_addr == p_addr, "R2 col addr stable at column strobe fall", dram_addr, p_addr);
        col_l = dram_addr;
        chk({row_l, col_l} == last_acc[19:0], "R2 row/col split", {row_l, col_l}, last_acc);
        if (first_cas) chk(lo_run >= T_RCD, "R10 row-to-column delay", lo_run, T_RCD);
        else           chk(cas_hi >= T_CP, "R10 column precharge", cas_hi, T_CP);
        first_cas = 1'b0;
        if (!dram_we_n) begin
          chk(!p_we, "R5 write strobe before column strobe", p_we, 0);
          chk(dram_dq_oe && dram_oe_n, "R5 data driven, oe high", {dram_dq_oe, dram_oe_n}, 3);
          dram_mem[int'({row_l, col_l})] = dram_dq_out;
        end
      end
      if (!dram_oe_n)
        chk(!dram_cas_n && dram_we_n, "R7 oe only in read column cycle", {dram_cas_n, dram_we_n}, 1);
      if (refresh_gnt)
        chk(dram_ras_n && dram_cas_n && !req_ready, "R9 grant with idle bus",
            {dram_ras_n, dram_cas_n, req_ready}, 6);
      if (dram_ras_n) begin hi_run++; lo_run = 0; end else begin lo_run++; hi_run = 0; end
      if (dram_cas_n) begin cas_hi++; cas_lo = 0; end else begin cas_lo++; cas_hi = 0; end
      if (dram_addr == p_addr) addr_run++; else addr_run = 1;
      if (!dram_ras_n) chk(lo_run <= T_RAS_MAX, "R8 row strobe low time", lo_run, T_RAS_MAX);
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected read data", rd_data, 0);
        else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R6 read data", rd_data, e);
        end
      end
      begin
        logic [3:0] v;
        v = dram_mem.exists(int'({row_l, col_l})) ? dram_mem[int'({row_l, col_l})] : 4'h0;
        if (!dram_cas_n && !dram_oe_n && cas_lo >= T_CAC && addr_run >= T_AA && lo_run >= T_RAC)
          dram_dq_in = v;
        else
          dram_dq_in = ~v;
      end
    end
    p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_addr = dram_addr;
  end

  task automatic do_req(input logic we, input logic [19:0] a, input logic [3:0] d);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    forever begin
      #1;
      if (req_ready) begin
        if (we) ref_mem[int'(a)] = d;
        else exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 4'h0);
        last_acc = int'(a);
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int f0;
    @(negedge clk);
    chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R1 strobes idle in reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dram_dq_oe && !rd_valid && !refresh_gnt, "R1 outputs quiet after reset",
        {dram_dq_oe, rd_valid, refresh_gnt}, 0);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    // page hits: two writes and two reads in row 5
    f0 = falls;
    do_req(1'b1, {10'd5, 10'd1}, 4'hA);
    do_req(1'b1, {10'd5, 10'd2}, 4'h3);
    do_req(1'b0, {10'd5, 10'd2}, 4'h0);
    do_req(1'b0, {10'd5, 10'd1}, 4'h0);
    chk(falls == f0 + 1 && !dram_ras_n, "R3 same row served without reopening", falls - f0, 1);
    drain();

    // row miss
    f0 = falls;
    do_req(1'b0, {10'd700, 10'd1}, 4'h0);
    do_req(1'b0, {10'd5, 10'd2}, 4'h0);
    drain();
    chk(falls - f0 >= 2, "R4 different row reopens", falls - f0, 2);

    // long same-row burst beyond the row strobe budget
    f0 = falls;
    for (int i = 0; i < 12; i++) do_req(1'b1, {10'd9, 10'(i * 3)}, 4'(i + 1));
    chk(falls - f0 >= 2, "R8 page closed by low-time limit", falls - f0, 2);
    for (int i = 0; i < 12; i++) do_req(1'b0, {10'd9, 10'(i * 3)}, 4'h0);
    drain();

    // refresh with an open page and a waiting request
    do_req(1'b1, {10'd9, 10'd500}, 4'h6);
    @(negedge clk);
    refresh_req = 1'b1;
    req_valid = 1'b1; req_we = 1'b0; req_addr = {10'd9, 10'd500};
    while (!refresh_gnt) @(negedge clk);
    chk(dram_ras_n, "R9 page closed before grant", dram_ras_n, 1);
    f0 = falls;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!req_ready, "R11 no acceptance under refresh", req_ready, 0);
    end
    chk(falls == f0, "R9 no row opened during grant", falls - f0, 0);
    refresh_req = 1'b0;
    do_req(1'b0, {10'd9, 10'd500}, 4'h0);
    drain();

    // mixed rows, reads in reverse order
    for (int i = 0; i < 16; i++) do_req(1'b1, {10'(20 + i % 3), 10'((i * 37) % 1024)}, 4'(i ^ 5));
    for (int i = 15; i >= 0; i--) do_req(1'b0, {10'(20 + i % 3), 10'((i * 37) % 1024)}, 4'h0);
    do_req(1'b0, {10'd1023, 10'd1023}, 4'h0);
    drain();
    chk(exp_q.size() == 0, "R11 every read answered", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule